// File: doc/BRIEF.md
# Three-Mode Reload/Capture Timer

This block is a 16-bit up-counter. Each count pulse advances it by one, and what it does when it passes all ones depends on the mode. In reload mode it loads a 16-bit holding pair and raises an overflow flag. In capture mode it wraps to zero, and a falling edge on an external trigger pin copies the live count into the holding pair. In baud mode it always reloads from the holding pair and gives a one-cycle tick to a serial port on every sixteenth overflow.

The count pulse is either an internal tick strobe or a falling edge on an external count pin. Both external pins are asynchronous and pass through two synchroniser flops before edge detection. An external-event flag records trigger edges in any mode while the external enable is set. Software reaches the control byte, the counter bytes and the holding bytes through a plain byte-wide register port: a write strobe with address and data, and a combinational read mux. The port is register access, not a data stream, so it has no valid/ready handshake and no back-pressure, and a write completes on the clock edge where it is strobed.

Register map: address 0 is control, 1 is counter low byte, 2 is counter high byte, 3 is holding low byte, 4 is holding high byte. Other addresses read zero. Control bits: 0 run, 1 capture select, 2 external count source, 3 external enable, 4 receive baud enable, 5 transmit baud enable, 6 overflow flag, 7 external-event flag.

Top module: `reload_capture_timer`

## Requirements
- R1: After reset every register reads 0, and ovf_flag_o, ext_flag_o and baud_tick_o are low.
- R2: Writes to addresses 0 to 4 update the fields given in the register map, and reads at those addresses return them.
- R3: With control bit 0 (run) low, the counter does not change on count pulses.
- R4: In reload mode (run=1, bit 1=0, bits 4 and 5 both 0), each count pulse adds one. A pulse at 0xFFFF loads the holding pair instead and sets the overflow flag (bit 6).
- R5: In capture mode (bit 1=1, bits 4 and 5 both 0), a pulse at 0xFFFF wraps the counter to 0 and sets the overflow flag, and the holding pair is left unchanged.
- R6: In capture mode with external enable (bit 3) set, a falling edge on trig_i copies the counter into the holding pair, whether run is set or not. With bit 3 clear, no copy is made.
- R7: With bit 3 set, a falling edge on trig_i sets the external-event flag (bit 7) in every mode. With bit 3 clear it does not. In reload mode the edge leaves the holding pair unchanged.
- R8: With bit 4 or bit 5 set (baud mode), every overflow reloads from the holding pair even if bit 1 is 1. The overflow flag is not set, and trigger edges do not capture.
- R9: In baud mode, baud_tick_o pulses high for one cycle on every 16th overflow.
- R10: With bit 2 set, the counter counts synchronised falling edges of ext_count_i and ignores tick_i. With bit 2 clear, it counts cycles with tick_i high.
- R11: A flag is cleared only by a write of 0 to its bit at address 0. A write of 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R12: A write to a counter byte in the same cycle as a count pulse stores the written byte, keeps the other byte, and drops that increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Internal count strobe |
| ext_count_i | input | 1 | Asynchronous external count pin, falling edges counted |
| trig_i | input | 1 | Asynchronous trigger pin, falling edges detected |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External-event flag |
| baud_tick_o | output | 1 | Serial bit-clock tick |

## Verification
Two pairs of functions can fall in the same cycle.

The first is a software write to a counter byte and a count pulse. The bench holds tick_i high and strobes a write to the low byte. It then samples half a cycle after the write edge, expecting exactly the written byte, and one cycle later expecting that byte plus one.

The second is a clearing write to the control byte and a hardware overflow set. The holding pair is loaded with 0xFFFF so that every tick overflows, and the bench writes 0 to the flag bit while ticking. The flag must still read 1.

Reload, capture and baud periods are swept over several holding values and pulse counts, with the expected count computed from the reload period.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic ext_flag;  // bit 7
    logic ovf_flag;  // bit 6
    logic tx_baud;   // bit 5
    logic rx_baud;   // bit 4
    logic ext_en;    // bit 3
    logic cnt_ext;   // bit 2
    logic cap_sel;   // bit 1
    logic run;       // bit 0
  } ctrl_t;
endpackage

// File: rtl/rct_sync_edge.sv
module rct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  // R10
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/rct_baud_div.sv
module rct_baud_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (ovf_i) begin
        if (div_q == DW'(DIV - 1)) begin
          div_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  // R9
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rct_count_core.sv
module rct_count_core
  import rct_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_i,
  input  logic [7:0]       wdata_i,
  input  logic [WIDTH/8-1:0] cnt_byte_wr_i,
  input  logic [WIDTH/8-1:0] hold_byte_wr_i,
  input  logic             tick_i,
  input  logic             ext_fall_i,
  input  logic             trig_fall_i,
  output ctrl_t            ctl_o,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] hold_o,
  output logic             baud_ovf_o
);
  localparam int BYTES = WIDTH / 8;

  ctrl_t            ctl_q;
  logic [WIDTH-1:0] cnt_q, hold_q, cnt_d, hold_d;
  logic baud_mode, src, cnt_wr, inc, wrap, reload_sel, cap_evt, ext_evt;

  assign baud_mode  = ctl_q.rx_baud | ctl_q.tx_baud;
  assign src        = ctl_q.cnt_ext ? ext_fall_i : tick_i;
  assign cnt_wr     = |cnt_byte_wr_i;
  assign inc        = ctl_q.run & src & ~cnt_wr;
  assign wrap       = inc & (&cnt_q);
  assign reload_sel = baud_mode | ~ctl_q.cap_sel;
  assign cap_evt    = trig_fall_i & ctl_q.ext_en & ctl_q.cap_sel & ~baud_mode;
  assign ext_evt    = trig_fall_i & ctl_q.ext_en;

  always_comb begin
    cnt_d = cnt_q;
    for (int b = 0; b < BYTES; b++)
      if (cnt_byte_wr_i[b]) cnt_d[b*8 +: 8] = wdata_i;
    if (wrap)     cnt_d = reload_sel ? hold_q : '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    hold_d = hold_q;
    if (|hold_byte_wr_i) begin
      for (int b = 0; b < BYTES; b++)
        if (hold_byte_wr_i[b]) hold_d[b*8 +: 8] = wdata_i;
    end else if (cap_evt) begin
      hold_d = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      if (ctl_wr_i) begin
        ctl_q.run     <= wdata_i[0];
        ctl_q.cap_sel <= wdata_i[1];
        ctl_q.cnt_ext <= wdata_i[2];
        ctl_q.ext_en  <= wdata_i[3];
        ctl_q.rx_baud <= wdata_i[4];
        ctl_q.tx_baud <= wdata_i[5];
        ctl_q.ovf_flag <= (ctl_q.ovf_flag & wdata_i[6]) | (wrap & ~baud_mode);
        ctl_q.ext_flag <= (ctl_q.ext_flag & wdata_i[7]) | ext_evt;
      end else begin
        ctl_q.ovf_flag <= ctl_q.ovf_flag | (wrap & ~baud_mode);
        ctl_q.ext_flag <= ctl_q.ext_flag | ext_evt;
      end
    end
  end

  assign ctl_o      = ctl_q;
  assign cnt_o      = cnt_q;
  assign hold_o     = hold_q;
  assign baud_ovf_o = wrap & baud_mode;

  // R3
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !cnt_wr) |=> $stable(cnt_q));
  // R12
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_byte_wr_i[0] |=> cnt_q[7:0] == $past(wdata_i));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && reload_sel) |=> cnt_q == $past(hold_q));
  // R8
  baud_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_mode && !ctl_wr_i) |=> !$rose(ctl_q.ovf_flag));
  // R7
  ext_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> ctl_q.ext_flag);
endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer
  import rct_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BAUD_DIV    = 16,
  localparam int BYTES      = WIDTH / 8,
  localparam int ADDR_W     = $clog2(2 * BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ext_count_i,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              baud_tick_o
);
  logic             ext_fall, trig_fall, ctl_wr, baud_ovf;
  logic [BYTES-1:0] cnt_byte_wr, hold_byte_wr;
  ctrl_t            ctl;
  logic [WIDTH-1:0] cnt, hold;

  rct_sync_edge #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_count_i), .fall_o(ext_fall));
  rct_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(trig_i), .fall_o(trig_fall));

  assign ctl_wr = wr_en_i && (wr_addr_i == '0);

  for (genvar b = 0; b < BYTES; b++) begin : g_dec
    assign cnt_byte_wr[b]  = wr_en_i && (wr_addr_i == ADDR_W'(b + 1));
    assign hold_byte_wr[b] = wr_en_i && (wr_addr_i == ADDR_W'(BYTES + b + 1));
  end

  rct_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .wdata_i(wr_data_i),
    .cnt_byte_wr_i(cnt_byte_wr), .hold_byte_wr_i(hold_byte_wr),
    .tick_i(tick_i), .ext_fall_i(ext_fall), .trig_fall_i(trig_fall),
    .ctl_o(ctl), .cnt_o(cnt), .hold_o(hold), .baud_ovf_o(baud_ovf));

  rct_baud_div #(.DIV(BAUD_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .ovf_i(baud_ovf), .tick_o(baud_tick_o));

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) rd_data_o = ctl;
    for (int b = 0; b < BYTES; b++) begin
      if (rd_addr_i == ADDR_W'(b + 1))         rd_data_o = cnt[b*8 +: 8];
      if (rd_addr_i == ADDR_W'(BYTES + b + 1)) rd_data_o = hold[b*8 +: 8];
    end
  end

  assign ovf_flag_o = ctl.ovf_flag;
  assign ext_flag_o = ctl.ext_flag;

  // R1
  reset_out_chk: assert property (@(posedge clk) !rst_n |=> (!ovf_flag_o && !ext_flag_o && !baud_tick_o));
endmodule

// File: tb/reload_capture_timer_test.sv
module reload_capture_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RUN = 8'h01, CAP = 8'h02, EXT = 8'h04, EXEN = 8'h08,
                         RXB = 8'h10, TXB = 8'h20;

  logic clk = 0, rst_n = 0, tick = 0, ext_cnt = 1, trig = 1;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic ovf_flag, ext_flag, baud_tick;
  int errors = 0, checks = 0, btick_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_capture_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_count_i(ext_cnt), .trig_i(trig),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .ovf_flag_o(ovf_flag), .ext_flag_o(ext_flag),
    .baud_tick_o(baud_tick));

  always @(negedge clk) if (baud_tick) btick_cnt++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic set16(input logic [2:0] base, input logic [15:0] v);
    wr(base, v[7:0]); wr(base + 3'd1, v[15:8]);
  endtask

  task automatic rd16(input logic [2:0] base, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(base, lo); rd(base + 3'd1, hi); v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic trig_pulse();
    @(negedge clk); trig = 0;
    repeat (4) @(negedge clk);
    trig = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    logic [15:0] holds [4] = '{16'hFFF0, 16'hFFFD, 16'hFF80, 16'hFFFF};
    int ns [3] = '{3, 20, 300};

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b); check("R1 reg", b, 0);
    end
    check("R1 flags", {ovf_flag, ext_flag, baud_tick}, 0);

    // R2 register write/read
    set16(3'd1, 16'hA55A); set16(3'd3, 16'h3CC3); wr(0, EXEN | CAP);
    rd16(3'd1, v); check("R2 cnt", v, 16'hA55A);
    rd16(3'd3, v); check("R2 hold", v, 16'h3CC3);
    rd(0, b); check("R2 ctrl", b, EXEN | CAP);

    // R3 run low
    wr(0, 0); ticks(10); rd16(3'd1, v); check("R3 stopped", v, 16'hA55A);

    // R4 reload sweep
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 3; j++) begin
        int p, e;
        wr(0, 0); set16(3'd3, holds[i]); set16(3'd1, holds[i]); wr(0, RUN);
        ticks(ns[j]);
        p = 65536 - int'(holds[i]);
        e = int'(holds[i]) + (ns[j] % p);
        rd16(3'd1, v); check("R4 count", v, e);
        check("R4 flag", ovf_flag, (ns[j] >= p) ? 1 : 0);
      end
    end

    // R5 capture-mode wrap
    wr(0, 0); set16(3'd3, 16'h1234); set16(3'd1, 16'hFFFE); wr(0, RUN | CAP);
    ticks(3);
    rd16(3'd1, v); check("R5 wrap", v, 1);
    rd16(3'd3, v); check("R5 hold kept", v, 16'h1234);
    check("R5 flag", ovf_flag, 1);

    // R6 capture on trigger
    wr(0, 0); set16(3'd1, 16'h4321); set16(3'd3, 0); wr(0, CAP | EXEN);
    trig_pulse();
    rd16(3'd3, v); check("R6 capture", v, 16'h4321);
    check("R7 flag cap", ext_flag, 1);
    wr(0, CAP); set16(3'd1, 16'h7777); trig_pulse();
    rd16(3'd3, v); check("R6 no capture", v, 16'h4321);
    check("R7 no flag", ext_flag, 0);
    // R7 reload mode edge
    wr(0, EXEN); trig_pulse();
    rd16(3'd3, v); check("R7 hold kept", v, 16'h4321);
    check("R7 flag reload", ext_flag, 1);

    // R8/R9 baud mode
    wr(0, 0); set16(3'd3, 16'hFFFE); set16(3'd1, 16'hFFFE);
    wr(0, RUN | CAP | RXB);
    btick_cnt = 0;
    ticks(320); repeat (3) @(negedge clk);
    check("R9 baud ticks", btick_cnt, 10);
    rd16(3'd1, v); check("R8 reload", v, 16'hFFFE);
    check("R8 no flag", ovf_flag, 0);
    wr(0, CAP | TXB | EXEN); set16(3'd1, 16'h0042); trig_pulse();
    rd16(3'd3, v); check("R8 no capture", v, 16'hFFFE);
    check("R7 flag baud", ext_flag, 1);

    // R10 external count source
    wr(0, 0); set16(3'd1, 16'h0010); wr(0, RUN | EXT);
    @(negedge clk); tick = 1;
    for (int k = 0; k < 7; k++) begin
      ext_cnt = 0; repeat (3) @(negedge clk);
      ext_cnt = 1; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk); tick = 0;
    rd16(3'd1, v); check("R10 ext count", v, 16'h0017);

    // R12 write vs increment
    wr(0, 0); set16(3'd1, 16'h0100); wr(0, RUN);
    rd_addr = 3'd1;
    @(negedge clk); tick = 1;
    repeat (5) @(negedge clk);
    wr_en = 1; wr_addr = 3'd1; wr_data = 8'h55;
    @(negedge clk); wr_en = 0; #1;
    check("R12 write wins", rd_data, 8'h55);
    @(negedge clk); #1;
    check("R12 next inc", rd_data, 8'h56);
    tick = 0;
    rd(3'd2, b); check("R12 high kept", b, 8'h01);

    // R11 flag set vs clear
    wr(0, 0); set16(3'd3, 16'hFFFF); set16(3'd1, 16'hFFFF); wr(0, RUN);
    @(negedge clk); tick = 1;
    repeat (3) @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = RUN;
    @(negedge clk); wr_en = 0; #1;
    check("R11 set wins", ovf_flag, 1);
    tick = 0;
    wr(0, RUN | 8'h40); check("R11 write1 keeps", ovf_flag, 1);
    wr(0, RUN); check("R11 clear", ovf_flag, 0);
    wr(0, 8'hC0); check("R11 write1 no set", {ovf_flag, ext_flag}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule